// File: doc/BRIEF.md
# Buffered Serial Transmitter with Line Break Control

This block sends bytes on an asynchronous serial line. A host queues bytes in a 16-entry buffer through a small register interface. A shift engine takes the bytes out of the buffer and sends each one as a frame. Each frame has a low start bit, eight data bits sent least significant bit first, and a high stop bit. Each bit lasts `CLKS_PER_BIT` system clocks.

Two status flags pace the host, and the host clears them in software. The room flag tells the host when the buffer has drained to a programmed level, so more bytes can be written. The done flag tells the host when the whole queue has left the line. The host reads the fill level at any time.

When sending is disabled, two port-control bits drive the line directly. This lets the host hold the line low to send a break, or leave it high.

Top module: `fifo_uart_tx`

Register map (2-bit address; read data is 0 for bits not listed):

| Address | Access | Bits |
|---|---|---|
| 0 | write | [7:0] byte to queue |
| 1 | read/write | [0] send enable, [2:1] level select, [3] pin drive enable, [4] pin value |
| 2 | read/write | [0] room flag, [1] done flag |
| 3 | read | [4:0] queued byte count |

## Requirements
- R1: After reset, the count reads 0, the control register reads 0, both flags read 1, and `txd` is high.
- R2: The buffer holds up to 16 bytes. The count register reports the number of queued bytes, and each accepted write to address 0 raises it by one.
- R3: A write to address 0 while 16 bytes are queued is dropped, and the count stays at 16.
- R4: While sending is enabled, each queued byte leaves in write order. Each frame is one low start bit, eight data bits with bit 0 first, and one high stop bit, each `CLKS_PER_BIT` clocks long. The start bit begins on the cycle after the byte leaves the buffer.
- R5: The room flag sets when the count moves from above the trigger level to at or below it. The level select field maps 0, 1, 2, 3 to levels 0, 2, 4, 8.
- R6: Writing 0 to a flag bit at address 2 clears that flag only if the flag was read as 1 at address 2 since its last clear. Writing 1 to a flag bit has no effect. A clear without a prior read has no effect.
- R7: The done flag sets when a stop bit completes and the buffer is empty. A frame cut off by disabling does not set it.
- R8: With sending disabled, `txd` equals the pin value when pin drive is enabled, and is high otherwise. Pin drive enabled with pin value 0 produces a break.
- R9: With sending enabled and nothing to send, `txd` is high.
- R10: Clearing send enable in the middle of a frame abandons that frame at once. The bytes still queued stay in the buffer and are sent after sending is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of address 2 arms flag clearing |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for `reg_addr`, combinational |
| txd | output | 1 | Serial output line |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never active in the same cycle and that every strobe lasts exactly one clock. The bench drives each register access as a single one-cycle pulse launched on the falling clock edge, and never overlaps a read with a write. The checks on the full-buffer drop rely on the host not writing while the shift engine pops. The bench therefore fills the buffer while sending is disabled. Random byte values and fill counts are drawn only from the range in which the room-flag crossing can be observed, between trigger level plus two and 16.

// File: rtl/fut_pkg.sv
package fut_pkg;

    localparam int REG_W = 8;

    typedef enum logic [1:0] {
        ADDR_DATA  = 2'd0,
        ADDR_CTRL  = 2'd1,
        ADDR_STAT  = 2'd2,
        ADDR_LEVEL = 2'd3
    } reg_addr_e;

    typedef enum logic [1:0] {
        LN_IDLE,
        LN_START,
        LN_DATA,
        LN_STOP
    } line_state_e;

    // Control register layout, bit 0 at the bottom.
    typedef struct packed {
        logic       pin_val;
        logic       pin_oe;
        logic [1:0] trig_sel;
        logic       tx_en;
    } ctrl_t;

    localparam int CTRL_W   = $bits(ctrl_t);
    localparam int NFLAGS   = 2;
    localparam int FLAG_ROOM = 0;
    localparam int FLAG_DONE = 1;

    function automatic int unsigned trig_level(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 2;
            2'd2:    return 4;
            default: return 8;
        endcase
    endfunction

endpackage

// File: rtl/fut_fifo.sv
module fut_fifo #(
    parameter int DW    = 8,
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wptr, rptr;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = mem[rptr];

    function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (do_push) wptr <= next_ptr(wptr);
            if (do_pop)  rptr <= next_ptr(rptr);
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/fut_shifter.sv
module fut_shifter
    import fut_pkg::*;
#(
    parameter int DW           = 8,
    parameter int CLKS_PER_BIT = 16,
    localparam int TW          = $clog2(CLKS_PER_BIT),
    localparam int BW          = $clog2(DW)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          src_empty,
    input  logic [DW-1:0] src_data,
    output logic          pop,
    output logic          line,
    output logic          frame_done,
    output logic          idle
);

    line_state_e   state;
    logic [TW-1:0] tick;
    logic [BW-1:0] bitn;
    logic [DW-1:0] shreg;
    logic          bit_end;

    assign bit_end    = (tick == TW'(CLKS_PER_BIT - 1));
    assign idle       = (state == LN_IDLE);
    assign pop        = en && idle && !src_empty;
    assign frame_done = en && (state == LN_STOP) && bit_end;

    always_comb begin
        case (state)
            LN_START: line = 1'b0;
            LN_DATA:  line = shreg[0];
            default:  line = 1'b1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= LN_IDLE;
            tick  <= '0;
            bitn  <= '0;
            shreg <= '0;
        end else begin
            tick <= (idle || bit_end) ? '0 : tick + 1'b1;
            case (state)
                LN_IDLE: if (pop) begin
                    shreg <= src_data;
                    state <= LN_START;
                end
                LN_START: if (bit_end) begin
                    bitn  <= '0;
                    state <= LN_DATA;
                end
                LN_DATA: if (bit_end) begin
                    shreg <= shreg >> 1;
                    if (bitn == BW'(DW - 1)) state <= LN_STOP;
                    else                     bitn  <= bitn + 1'b1;
                end
                default: if (bit_end) state <= LN_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fut_flag_cell.sv
module fut_flag_cell (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic rd_strobe,
    input  logic clr_req,
    output logic flag
);

    logic armed;
    logic clr_ok;

    assign clr_ok = clr_req && armed && flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag  <= 1'b1;
            armed <= 1'b0;
        end else begin
            if (set_evt)     flag <= 1'b1;
            else if (clr_ok) flag <= 1'b0;

            if (clr_ok)                armed <= 1'b0;
            else if (rd_strobe && flag) armed <= 1'b1;
        end
    end

endmodule

// File: rtl/fifo_uart_tx.sv
module fifo_uart_tx
    import fut_pkg::*;
#(
    parameter int DW           = 8,
    parameter int DEPTH        = 16,
    parameter int CLKS_PER_BIT = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       reg_addr,
    input  logic             reg_wr,
    input  logic             reg_rd,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    output logic             txd
);

    localparam int CW = $clog2(DEPTH + 1);

    ctrl_t              ctrl;
    logic               fifo_push, fifo_pop, fifo_full, fifo_empty;
    logic [DW-1:0]      fifo_head;
    logic [CW-1:0]      fifo_count;
    logic               sh_line, sh_idle, frame_done;
    logic               room_cond, room_cond_q;
    logic               stat_wr, stat_rd;
    logic [NFLAGS-1:0]  fl_set, fl_val;
    logic               flag_room, flag_done;
    logic               unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_W-1:CTRL_W];

    assign fifo_push = reg_wr && (reg_addr == ADDR_DATA);
    assign stat_wr   = reg_wr && (reg_addr == ADDR_STAT);
    assign stat_rd   = reg_rd && (reg_addr == ADDR_STAT);

    always_ff @(posedge clk) begin
        if (rst)                                     ctrl <= '0;
        else if (reg_wr && (reg_addr == ADDR_CTRL))  ctrl <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
    end

    fut_fifo #(.DW(DW), .DEPTH(DEPTH)) fifo_i (
        .clk      (clk),
        .rst      (rst),
        .push     (fifo_push),
        .push_data(reg_wdata[DW-1:0]),
        .pop      (fifo_pop),
        .head     (fifo_head),
        .count    (fifo_count),
        .full     (fifo_full),
        .empty    (fifo_empty)
    );

    fut_shifter #(.DW(DW), .CLKS_PER_BIT(CLKS_PER_BIT)) shifter_i (
        .clk       (clk),
        .rst       (rst),
        .en        (ctrl.tx_en),
        .src_empty (fifo_empty),
        .src_data  (fifo_head),
        .pop       (fifo_pop),
        .line      (sh_line),
        .frame_done(frame_done),
        .idle      (sh_idle)
    );

    // Room flag sets on the crossing into the at-or-below-level region.
    assign room_cond = (32'(fifo_count) <= trig_level(ctrl.trig_sel));

    always_ff @(posedge clk) begin
        if (rst) room_cond_q <= 1'b1;
        else     room_cond_q <= room_cond;
    end

    assign fl_set[FLAG_ROOM] = room_cond && !room_cond_q;
    assign fl_set[FLAG_DONE] = frame_done && fifo_empty;

    for (genvar g = 0; g < NFLAGS; g++) begin : g_flag
        fut_flag_cell cell_i (
            .clk      (clk),
            .rst      (rst),
            .set_evt  (fl_set[g]),
            .rd_strobe(stat_rd),
            .clr_req  (stat_wr && !reg_wdata[g]),
            .flag     (fl_val[g])
        );
    end

    assign flag_room = fl_val[FLAG_ROOM];
    assign flag_done = fl_val[FLAG_DONE];

    always_comb begin
        case (reg_addr)
            ADDR_CTRL:  reg_rdata = REG_W'(ctrl);
            ADDR_STAT:  reg_rdata = REG_W'(fl_val);
            ADDR_LEVEL: reg_rdata = REG_W'(fifo_count);
            default:    reg_rdata = '0;
        endcase
    end

    always_comb begin
        if (ctrl.tx_en)      txd = sh_line;
        else if (ctrl.pin_oe) txd = ctrl.pin_val;
        else                 txd = 1'b1;
    end

endmodule

// File: rtl/fut_checker.sv
module fut_checker #(
    parameter int DEPTH = 16,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    reg_addr,
    input logic          reg_wr,
    input logic [7:0]    reg_wdata,
    input logic          txd,
    input logic          tx_en,
    input logic          pin_oe,
    input logic          pin_val,
    input logic          fifo_push,
    input logic          fifo_full,
    input logic          fifo_pop,
    input logic [CW-1:0] fifo_count,
    input logic          fifo_empty,
    input logic          sh_idle,
    input logic          frame_done,
    input logic          flag_room,
    input logic          flag_done
);

    a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
        fifo_count <= CW'(DEPTH));

    a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (fifo_push && fifo_full && !fifo_pop) |=> (fifo_count == $past(fifo_count)));

    a_r4_start_after_pop: assert property (@(posedge clk) disable iff (rst)
        (tx_en && fifo_pop) |=> (!txd || !tx_en));

    a_r6_room_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_room) |-> $past(reg_wr && reg_addr == 2'd2 && !reg_wdata[0]));

    a_r6_done_clear_by_write: assert property (@(posedge clk) disable iff (rst)
        $fell(flag_done) |-> $past(reg_wr && reg_addr == 2'd2 && !reg_wdata[1]));

    a_r7_done_sets: assert property (@(posedge clk) disable iff (rst)
        (frame_done && fifo_empty) |=> flag_done);

    a_r8_break_low: assert property (@(posedge clk) disable iff (rst)
        (!tx_en && pin_oe && !pin_val) |-> !txd);

    a_r9_idle_high: assert property (@(posedge clk) disable iff (rst)
        (tx_en && sh_idle) |-> txd);

endmodule

bind fifo_uart_tx fut_checker #(.DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .txd       (txd),
    .tx_en     (ctrl.tx_en),
    .pin_oe    (ctrl.pin_oe),
    .pin_val   (ctrl.pin_val),
    .fifo_push (fifo_push),
    .fifo_full (fifo_full),
    .fifo_pop  (fifo_pop),
    .fifo_count(fifo_count),
    .fifo_empty(fifo_empty),
    .sh_idle   (sh_idle),
    .frame_done(frame_done),
    .flag_room (flag_room),
    .flag_done (flag_done)
);

// File: tb/fifo_uart_tx_tb_top.sv
module fifo_uart_tx_tb_top;

    localparam int CPB = 16;
    localparam logic [1:0] A_DATA = 2'd0, A_CTRL = 2'd1, A_STAT = 2'd2, A_LEVEL = 2'd3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       txd;

    int n_checks = 0;
    int n_fail   = 0;
    logic [7:0] exp_mem [256];
    int exp_wr = 0;
    int exp_rd = 0;
    bit mon_on = 1'b0;

    always #10 clk = ~clk;

    fifo_uart_tx #(.DW(8), .DEPTH(16), .CLKS_PER_BIT(CPB)) dut_i (
        .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .txd(txd)
    );

    function automatic int level_of(input int sel);
        int lv [4] = '{0, 2, 4, 8};
        return lv[sel];
    endfunction

    function automatic logic [7:0] ctrl_word(input bit en, input int sel, input bit oe, input bit pv);
        return {3'b000, pv, oe, 2'(sel), en};
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #5 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic push(input logic [7:0] b, input bit track);
        reg_write(A_DATA, b);
        if (track) begin
            exp_mem[exp_wr % 256] = b;
            exp_wr++;
        end
    endtask

    task automatic wait_done(input string req);
        logic [7:0] d;
        for (int i = 0; i < 6000; i++) begin
            reg_read(A_STAT, d);
            if (d[1]) break;
        end
        check(req, int'(d[1]), 1);
    endtask

    // Line monitor: decodes frames at mid-bit and compares with the queue.
    initial begin
        logic [7:0] got;
        logic st, sp;
        forever begin
            @(negedge txd);
            if (mon_on) begin
                repeat (CPB / 2) @(posedge clk);
                #2 st = txd;
                for (int b = 0; b < 8; b++) begin
                    repeat (CPB) @(posedge clk);
                    #2 got[b] = txd;
                end
                repeat (CPB) @(posedge clk);
                #2 sp = txd;
                check("R4 start bit", int'(st), 0);
                check("R4 stop bit", int'(sp), 1);
                check("R4 byte order/value", int'(got), int'(exp_mem[exp_rd % 256]));
                exp_rd++;
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [7:0] lost;
        void'($urandom(32'd20240611));
        repeat (4) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1 reset state
        check("R1 txd", int'(txd), 1);
        reg_read(A_LEVEL, d); check("R1 count", int'(d), 0);
        reg_read(A_CTRL, d);  check("R1 ctrl", int'(d), 0);

        // R6: clear attempt without prior read has no effect (also R1 flags)
        reg_write(A_STAT, 8'h00);
        reg_read(A_STAT, d); check("R6 no clear without read / R1 flags", int'(d), 3);
        // R6: writing 1 leaves room flag, writing 0 clears armed done flag
        reg_write(A_STAT, 8'h01);
        reg_read(A_STAT, d); check("R6 selective clear", int'(d), 1);

        // R8 break and pin control
        reg_write(A_CTRL, ctrl_word(0, 0, 1, 0)); #2 check("R8 break low", int'(txd), 0);
        reg_write(A_CTRL, ctrl_word(0, 0, 1, 1)); #2 check("R8 pin high", int'(txd), 1);
        reg_write(A_CTRL, ctrl_word(0, 0, 0, 0)); #2 check("R8 undriven high", int'(txd), 1);

        // R2 fill, R3 overflow drop
        for (int i = 0; i < 16; i++) begin
            push(8'($urandom), 1);
            reg_read(A_LEVEL, d); check("R2 count", int'(d), i + 1);
        end
        push(8'hA5, 0);
        reg_read(A_LEVEL, d); check("R3 full write dropped", int'(d), 16);

        // Drain all 16 bytes (R4, R7, R9)
        mon_on = 1'b1;
        reg_write(A_CTRL, ctrl_word(1, 3, 0, 0));
        reg_read(A_STAT, d); check("R7 done clear while sending", int'(d[1]), 0);
        wait_done("R7 done after drain");
        reg_read(A_LEVEL, d); check("R2 empty after drain", int'(d), 0);
        check("R4 all frames seen", exp_rd, exp_wr);
        #2 check("R9 idle high", int'(txd), 1);

        // Random fills per level select: R5 crossings, R6 clears
        for (int it = 0; it < 8; it++) begin
            int sel, trig, n;
            bit seen;
            sel  = it % 4;
            trig = level_of(sel);
            n    = trig + 2 + int'($urandom % (15 - trig));
            mon_on = 1'b0;
            reg_write(A_CTRL, ctrl_word(0, sel, 0, 0));
            reg_read(A_STAT, d);
            reg_write(A_STAT, 8'h01);
            for (int i = 0; i < n; i++) push(8'($urandom), 1);
            reg_read(A_STAT, d);
            reg_write(A_STAT, 8'h02);
            reg_read(A_STAT, d); check("R6 room cleared after read", int'(d), 0);
            mon_on = 1'b1;
            reg_write(A_CTRL, ctrl_word(1, sel, 0, 0));
            seen = 1'b0;
            for (int g = 0; g < 8000; g++) begin
                reg_read(A_LEVEL, d);
                if (int'(d) == trig + 1 && !seen) begin
                    seen = 1'b1;
                    reg_read(A_STAT, d); check("R5 room clear above level", int'(d[0]), 0);
                end else if (int'(d) <= trig) begin
                    reg_read(A_STAT, d); check("R5 room set at level", int'(d[0]), 1);
                    break;
                end
            end
            wait_done("R7 done after random drain");
            reg_read(A_LEVEL, d); check("R2 empty", int'(d), 0);
            check("R4 frames matched", exp_rd, exp_wr);
        end

        // R10: disable mid-frame
        mon_on = 1'b0;
        reg_write(A_CTRL, ctrl_word(0, 0, 0, 0));
        reg_read(A_STAT, d);
        reg_write(A_STAT, 8'h01);
        lost = 8'h3C;
        push(lost, 0);
        push(8'hC3, 0);
        reg_write(A_CTRL, ctrl_word(1, 0, 0, 0));
        repeat (3 * CPB) @(posedge clk);
        reg_write(A_CTRL, ctrl_word(0, 0, 0, 0));
        #2 check("R10 line released", int'(txd), 1);
        reg_read(A_LEVEL, d); check("R10 remaining queued", int'(d), 1);
        repeat (12 * CPB) @(posedge clk);
        reg_read(A_STAT, d); check("R7 no done on abort", int'(d[1]), 0);
        exp_mem[exp_wr % 256] = 8'hC3;
        exp_wr++;
        mon_on = 1'b1;
        reg_write(A_CTRL, ctrl_word(1, 0, 0, 0));
        wait_done("R10 resume done");
        check("R10 kept byte sent", exp_rd, exp_wr);

        report();
        $finish;
    end

endmodule